// File: doc/BRIEF.md
# Serial Trace-Byte Inserter

This block supplies a framer's transmit overhead input with a path trace byte, one bit at a time. It watches two strobes, a slot-enable strobe and a frame-position strobe, which the framer produces in its overhead clock domain. Both strobes are sampled on rising edges of that clock. When both are high on the same rising edge and no byte is in flight, the block launches one byte, most significant bit first. Each bit is driven on a falling edge, so that the framer can capture it on the rising edge that follows.

The bytes come from a 64-entry trace-message store, which is written through a simple address/data/strobe port. A length-select input makes the message either 16 or 64 bytes long. A read pointer steps one entry forward after each completed byte and returns to entry 0 after the last one. An insert-enable output tells the framer that externally supplied overhead is in use. It is high while a byte is in flight, and it can be tied high through a hold input when insertion is already enabled by configuration. A one-cycle completion pulse marks the end of every byte.

Top module: `poh_trace_inserter`

## Requirements
- R1: `trig_en_i` and `trig_frm_i` are sampled on rising edges of `oh_clk`. A transfer starts on a rising edge only when both are sampled high on that edge and the block is idle. A single strobe alone starts nothing.
- R2: The first bit of a transfer is bit 7 (the MSB) of the byte. It appears on `ser_o` at the falling edge right after the trigger edge and stays there through the next rising edge.
- R3: Bits 6 down to 0 follow in descending order, one per falling edge, on the seven falling edges after the MSB.
- R4: A transfer lasts exactly eight rising edges after its trigger edge. From the falling edge after the eighth of these edges, `ser_o` is low again. A new trigger is accepted from the rising edge after that.
- R5: A trigger sampled while a transfer is in flight is ignored, including one on the rising edge that captures the eighth bit. The byte in flight always completes all eight bits.
- R6: `done_o` is high for exactly one cycle. It goes high on the rising edge that captures the eighth bit.
- R7: A store write (`wr_en_i` high on a rising edge) places `wr_data_i` at entry `wr_addr_i` (0 to 63). Each transfer sends the entry at the current read pointer.
- R8: When `long_msg_i` is 0 the message has 16 entries (0 to 15); when it is 1 the message has 64 entries (0 to 63). The pointer advances by one per completed transfer and returns to 0 after the last entry. If the pointer is at or above the last entry when the transfer ends (for example, after switching from 64 to 16), it returns to 0.
- R9: `ins_o` equals `ins_hold_i` OR (transfer in flight).
- R10: With `rst_n` low on a rising edge, the block aborts any transfer and clears the bit counter and the read pointer to 0. `ser_o` goes low on the next falling edge and `done_o` goes low.
- R11: While no transfer is in flight, `ser_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oh_clk | input | 1 | Overhead clock; strobes sampled on rising edge, bits launched on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_en_i | input | 1 | Overhead slot-enable strobe from the framer |
| trig_frm_i | input | 1 | Frame-position strobe from the framer |
| wr_en_i | input | 1 | Store write strobe |
| wr_addr_i | input | 6 | Store write address |
| wr_data_i | input | 8 | Store write data |
| long_msg_i | input | 1 | 0 = 16-byte message, 1 = 64-byte message |
| ins_hold_i | input | 1 | Forces `ins_o` high |
| ser_o | output | 1 | Serial trace bit to the framer |
| ins_o | output | 1 | Insert-enable to the framer |
| done_o | output | 1 | One-cycle pulse at the end of each byte |

## Verification
The bench holds both strobes high across the whole transfer, including the edge that captures the last bit. A design that restarts there would put a second MSB on the line where idle low is expected. Single-strobe pulses are scattered through idle time, so a design that triggers on either strobe alone would emit a stray byte and skew the pointer. The message length is shrunk while the pointer sits above entry 15, which catches a design that wraps only on equality. A reset arrives in the middle of a byte, which catches a design that leaves the line driven or keeps the pointer.

// File: rtl/poh_trace_pkg.sv
package poh_trace_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned SHORT_LEN = 16;
  localparam int unsigned LONG_LEN  = 64;
  localparam int unsigned PTR_W     = $clog2(LONG_LEN);
  localparam int unsigned CNT_W     = $clog2(BYTE_W);

  // index of the final entry for the selected message length
  function automatic int unsigned msg_last(input logic long_sel);
    return (long_sel ? LONG_LEN : SHORT_LEN) - 1;
  endfunction

  // pointer after a completed byte; anything at or past the end wraps
  function automatic int unsigned ptr_next(input int unsigned ptr,
                                           input logic long_sel);
    return (ptr >= msg_last(long_sel)) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/trace_store.sv
module trace_store
  import poh_trace_pkg::*;
#(
  parameter int unsigned DEPTH = LONG_LEN,
  parameter int unsigned W     = BYTE_W,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] hit;

  for (genvar e = 0; e < DEPTH; e++) begin : g_dec
    assign hit[e] = wr_en && (wr_addr == AW'(e));
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (hit[e]) mem[e] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/trace_pointer.sv
module trace_pointer
  import poh_trace_pkg::*;
#(
  parameter int unsigned AW = PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          long_sel,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_nx;

  always_comb begin
    ptr_nx = ptr;
    if (advance) ptr_nx = AW'(ptr_next(int'(ptr), long_sel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nx;
  end
endmodule

// File: rtl/bit_serializer.sv
module bit_serializer
  import poh_trace_pkg::*;
#(
  parameter int unsigned W  = BYTE_W,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig,
  input  logic [W-1:0] load_byte,
  output logic         busy,
  output logic         head_bit,
  output logic         start,
  output logic         last,
  output logic         done
);
  logic [W-1:0]  shreg;
  logic [CW-1:0] sent;

  assign start    = trig && !busy;
  assign last     = busy && (sent == CW'(W - 1));
  assign head_bit = shreg[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '0;
      sent  <= '0;
      done  <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        busy  <= 1'b1;
        shreg <= load_byte;
        sent  <= '0;
      end else if (last) begin
        busy  <= 1'b0;
        shreg <= '0;
        sent  <= '0;
      end else if (busy) begin
        shreg <= {shreg[W-2:0], 1'b0};
        sent  <= sent + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fall_launch.sv
module fall_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic head_bit,
  output logic ser
);
  // launched on the falling edge, captured by the framer on the rising edge
  always_ff @(negedge clk) begin
    if (!rst_n)    ser <= 1'b0;
    else if (busy) ser <= head_bit;
    else           ser <= 1'b0;
  end
endmodule

// File: rtl/poh_trace_inserter.sv
module poh_trace_inserter
  import poh_trace_pkg::*;
(
  input  logic             oh_clk,
  input  logic             rst_n,
  input  logic             trig_en_i,
  input  logic             trig_frm_i,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic             long_msg_i,
  input  logic             ins_hold_i,
  output logic             ser_o,
  output logic             ins_o,
  output logic             done_o
);
  logic              trig_pair;
  logic              xfer_start;
  logic              xfer_last;
  logic              xfer_busy;
  logic              head_bit;
  logic [PTR_W-1:0]  rd_ptr;
  logic [BYTE_W-1:0] cur_byte;

  assign trig_pair = trig_en_i && trig_frm_i;

  trace_store #(.DEPTH(LONG_LEN), .W(BYTE_W)) u_store (
    .clk     (oh_clk),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .rd_addr (rd_ptr),
    .rd_data (cur_byte)
  );

  trace_pointer #(.AW(PTR_W)) u_ptr (
    .clk      (oh_clk),
    .rst_n    (rst_n),
    .advance  (xfer_last),
    .long_sel (long_msg_i),
    .ptr      (rd_ptr)
  );

  bit_serializer #(.W(BYTE_W)) u_ser (
    .clk       (oh_clk),
    .rst_n     (rst_n),
    .trig      (trig_pair),
    .load_byte (cur_byte),
    .busy      (xfer_busy),
    .head_bit  (head_bit),
    .start     (xfer_start),
    .last      (xfer_last),
    .done      (done_o)
  );

  fall_launch u_launch (
    .clk      (oh_clk),
    .rst_n    (rst_n),
    .busy     (xfer_busy),
    .head_bit (head_bit),
    .ser      (ser_o)
  );

  assign ins_o = ins_hold_i || xfer_busy;
endmodule

// File: rtl/poh_trace_inserter_chk.sv
module poh_trace_inserter_chk
  import poh_trace_pkg::*;
(
  input logic             oh_clk,
  input logic             rst_n,
  input logic             trig_en_i,
  input logic             trig_frm_i,
  input logic             long_msg_i,
  input logic             ser_o,
  input logic             done_o,
  input logic             xfer_busy,
  input logic             xfer_last,
  input logic [PTR_W-1:0] rd_ptr
);
  logic [CNT_W:0] run_len;

  always_ff @(posedge oh_clk) begin
    if (!rst_n)         run_len <= '0;
    else if (xfer_busy) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  AST_START_BOTH_STROBES: assert property (@(posedge oh_clk) disable iff (!rst_n)
    $rose(xfer_busy) |-> $past(trig_en_i && trig_frm_i)); // R1
  AST_NO_RETRIGGER: assert property (@(posedge oh_clk) disable iff (!rst_n)
    xfer_busy && !xfer_last |=> xfer_busy); // R5
  AST_EIGHT_EDGES: assert property (@(posedge oh_clk) disable iff (!rst_n)
    $fell(xfer_busy) |-> run_len == (CNT_W + 1)'(BYTE_W)); // R4
  AST_DONE_SINGLE: assert property (@(posedge oh_clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge oh_clk) disable iff (!rst_n)
    done_o |-> $past(xfer_busy)); // R6
  AST_IDLE_LOW: assert property (@(posedge oh_clk) disable iff (!rst_n)
    !xfer_busy |-> !ser_o); // R11
  AST_PTR_STEP: assert property (@(posedge oh_clk) disable iff (!rst_n)
    done_o |-> rd_ptr == PTR_W'(ptr_next(int'($past(rd_ptr)), $past(long_msg_i)))); // R8
  AST_PTR_HOLD: assert property (@(posedge oh_clk) disable iff (!rst_n)
    $past(rst_n) && !$past(xfer_last) |-> $stable(rd_ptr)); // R8
endmodule

bind poh_trace_inserter poh_trace_inserter_chk u_chk (
  .oh_clk     (oh_clk),
  .rst_n      (rst_n),
  .trig_en_i  (trig_en_i),
  .trig_frm_i (trig_frm_i),
  .long_msg_i (long_msg_i),
  .ser_o      (ser_o),
  .done_o     (done_o),
  .xfer_busy  (xfer_busy),
  .xfer_last  (xfer_last),
  .rd_ptr     (rd_ptr)
);

// File: tb/test_poh_trace_inserter.sv
module test_poh_trace_inserter;
  logic       oh_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_en_i = 1'b0, trig_frm_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [5:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       long_msg_i = 1'b0, ins_hold_i = 1'b0;
  logic       ser_o, ins_o, done_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] model_mem [64];
  int model_ptr = 0;

  always #5 oh_clk = ~oh_clk;

  poh_trace_inserter i_poh_trace_inserter (.*);

  function automatic int exp_next(int p, logic lng);
    int last_ix = lng ? 63 : 15;
    return (p >= last_ix) ? 0 : p + 1;
  endfunction

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // all tasks start and end at a drive point (2 ns after a rising edge)
  task automatic write_entry(int a, logic [7:0] d);
    wr_en_i = 1; wr_addr_i = 6'(a); wr_data_i = d;
    #10; wr_en_i = 0;
    model_mem[a] = d;
  endtask

  task automatic idle_noise(int n);
    for (int c = 0; c < n; c++) begin
      int r = $urandom_range(0, 2);
      trig_en_i = (r == 1); trig_frm_i = (r == 2);
      #5;
      chk(ser_o, 0, "R1 single strobe/idle line");
      chk(done_o, 0, "R1 no done without both strobes");
      #5;
    end
    trig_en_i = 0; trig_frm_i = 0;
  endtask

  task automatic run_xfer(bit hold_all);
    logic [7:0] b = model_mem[model_ptr];
    trig_en_i = 1; trig_frm_i = 1;
    #10;                                  // trigger edge passed
    if (!hold_all) begin trig_en_i = 0; trig_frm_i = 0; end
    #5;
    for (int i = 0; i < 8; i++) begin
      chk(ser_o, b[7-i], (i == 0) ? "R2 msb first" : "R3 descending bit");
      chk(ins_o, 1, "R9 ins during transfer");
      chk(done_o, 0, "R6 no early done");
      #5;
      if (hold_all && i == 7) begin trig_en_i = 0; trig_frm_i = 0; end
      #5;
    end
    chk(done_o, 1, "R6 done after eighth bit");
    chk(ser_o, 0, "R4 line low after byte");
    chk(ins_o, ins_hold_i, "R9 ins follows hold when idle");
    model_ptr = exp_next(model_ptr, long_msg_i);
    #10;
    chk(done_o, 0, "R6 done is one cycle");
    chk(ser_o, 0, hold_all ? "R5 retrigger ignored" : "R11 idle low");
    #5;
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(posedge oh_clk); #2; @(posedge oh_clk); #2;
    #5;
    chk(ser_o, 0, "R10 reset line low");
    chk(done_o, 0, "R10 reset done low");
    chk(ins_o, 0, "R9 ins low at reset");
    #5;
    for (int a = 0; a < 64; a++) write_entry(a, 8'($urandom) | 8'h80);
    rst_n = 1;
    #10;
    // R7 / R8: short message walks 0..15 and wraps
    for (int k = 0; k < 18; k++) run_xfer(0);
    // R5: strobes held through the last bit edge, MSB set so restart shows
    run_xfer(1);
    run_xfer(1);
    // R9: hold forces insert-enable
    ins_hold_i = 1; #5; chk(ins_o, 1, "R9 hold drives ins"); #5;
    run_xfer(0);
    ins_hold_i = 0;
    // R8: long message, pointer beyond 15 then shorten
    long_msg_i = 1;
    while (model_ptr < 20) run_xfer(0);
    long_msg_i = 0;
    run_xfer(0);
    chk(model_ptr, 0, "R8 wrap from beyond short end");
    run_xfer(0);
    // R10: reset in mid byte
    trig_en_i = 1; trig_frm_i = 1; #10; trig_en_i = 0; trig_frm_i = 0;
    #30; rst_n = 0; #5;
    chk(ser_o, 0, "R10 line low after reset");
    #10; chk(done_o, 0, "R10 done low in reset");
    #5; rst_n = 1; model_ptr = 0;
    #10;
    run_xfer(0);
    chk(model_ptr, 1, "R10 pointer restarted at 0");
    // random mix: content rewrites, length flips, noise, transfers
    for (int it = 0; it < 150; it++) begin
      int act = $urandom_range(0, 9);
      if (act == 0) write_entry($urandom_range(0, 63), 8'($urandom));
      else if (act == 1) long_msg_i = ~long_msg_i;
      else if (act == 2) idle_noise($urandom_range(1, 6));
      else run_xfer(act == 3);
    end
    // full long wrap
    long_msg_i = 1;
    for (int k = 0; k < 66; k++) run_xfer(0);
    summary();
  end
endmodule